// File: doc/BRIEF.md
# Multiprocessor Serial Receiver with Address Wake-Up

This block receives asynchronous serial characters from a line that several stations share. Each character carries one extra bit after its data bits. When that bit is 1 the character is a station address; when it is 0 the character is payload. The line is oversampled by a baud tick at sixteen times the bit rate. Completed characters go into a receive data register with ready, overrun and framing flags, and an optional interrupt pulse.

To skip traffic meant for other stations, the host sets a wake-up enable. While it is set, payload characters are dropped without a trace: the data register does not change, no flag is raised and no interrupt fires. The next address character is taken in the normal way. It sets the address-flag output and clears the wake-up enable by hardware. The host then compares the address with its own. If they differ, it sets the wake-up enable again. A build-time switch selects 8 or 9 data bits. In 9-bit mode the top data bit appears on a separate output.

Top module: `mp_uart_rx`

## Requirements
- R1: A frame is one low start bit, the data bits LSB first, the address bit, and one stop bit. Each bit lasts 16 baud ticks. A start is accepted only if the line is still low 8 ticks after the falling edge; a shorter low pulse is discarded.
- R2: With the wake-up enable at 0, a completed character is written to the data register. `mpb_flag` takes the received address bit, and `rdrf` goes to 1.
- R3: With the wake-up enable at 1, a character whose address bit is 0 leaves the data register, `mpb_flag`, `rdrf`, `orer` and `fer` unchanged, and the wake-up enable stays 1.
- R4: A stop bit sampled low sets `fer` when the character is accepted. It has no effect on `fer` for a character ignored under R3.
- R5: With the wake-up enable at 1, a character whose address bit is 1 is accepted as under R2 (`mpb_flag`=1), and the wake-up enable returns to 0 on its own.
- R6: `irq` is a one-cycle pulse issued when a character is written to the data register while `rie` is 1. It does not fire when `rie` is 0 or when the character is ignored.
- R7: If an accepted character completes while `rdrf` is still 1 and no `rd_ack` is present, `orer` goes to 1 and the data register keeps its old value.
- R8: A `rd_ack` pulse clears `rdrf`. An `err_clr` pulse clears `orer` and `fer`. A `wake_set` pulse sets the wake-up enable, which is visible on `wake_en` one cycle later.
- R9: After reset, `rdrf`, `orer`, `fer`, `mpb_flag`, `wake_en`, `irq` and both data outputs are 0.
- R10: With `WIDE`=1 a frame carries 9 data bits; bit 8 appears on `rdata_hi` and bits 7..0 appear on `rdata_lo`. With `WIDE`=0, `rdata_hi` is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| baud_tick | input | 1 | Oversampling strobe, 16 per bit |
| wake_set | input | 1 | Pulse: set the wake-up enable |
| rie | input | 1 | Receive interrupt enable |
| rd_ack | input | 1 | Pulse: host has read data, clears `rdrf` |
| err_clr | input | 1 | Pulse: clears `orer` and `fer` |
| wake_en | output | 1 | Current wake-up enable |
| rdata_lo | output | 8 | Received data bits 7..0 |
| rdata_hi | output | 1 | Received data bit 8 (9-bit mode) |
| mpb_flag | output | 1 | Address bit of the last accepted character |
| rdrf | output | 1 | Receive data ready |
| orer | output | 1 | Overrun error |
| fer | output | 1 | Framing error |
| irq | output | 1 | Receive interrupt pulse |

## Verification
The bit counter and the wake-up state must be kept apart. A frame counter that slips one bit shows up within one character: the data is shifted, or the address bit is read from the wrong slot. A wrong address bit in turn changes `mpb_flag` and `wake_en` together. A wake-up enable that fails to gate a path shows at the ports as soon as the next payload character ends: `rdrf`, `fer` or `irq` rises when it should not, or `rdata_lo` changes. A missing auto-clear means the next payload character is lost after a valid address. All of these appear within one frame time of the character that triggers them.

// File: rtl/mpu_pkg.sv
// Package: types shared by the multiprocessor receiver modules.
// Assumes a maximum data width of 9 bits.
package mpu_pkg;

    localparam int MAX_DW = 9;

    // Receive framer phases.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_START = 3'd1,
        PH_DATA  = 3'd2,
        PH_MPB   = 3'd3,
        PH_STOP  = 3'd4
    } rx_phase_t;

    // One completed character as handed from framer to register stage.
    typedef struct packed {
        logic [MAX_DW-1:0] data;
        logic              mpb;
        logic              stop_ok;
    } rx_char_t;

endpackage

// File: rtl/mpu_rx_sync.sv
// Module: two-stage synchronizer for the asynchronous serial line.
// Assumes the line idles high, so reset loads ones.
module mpu_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/mpu_rx_framer.sv
// Module: oversampled frame receiver. It finds a start bit, confirms it
// at mid-bit, then samples the data bits (LSB first), the address bit
// and the stop bit at the middle of each bit. It emits a one-cycle
// done strobe with the character when the stop bit is sampled.
// Assumes baud_tick strobes OSR times per bit and the line is synchronous.
module mpu_rx_framer
    import mpu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rx,
    input  logic     tick,
    output logic     done,
    output rx_char_t chr
);
    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(MAX_DW + 1);
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR/2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);
    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(DATA_W - 1);

    rx_phase_t         phase;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [MAX_DW-1:0] shreg;
    logic              mpb_q;
    logic              at_end;

    assign at_end = (cnt == LAST_CNT);

    // Frame sequencing, bit sampling and character hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
            mpb_q <= 1'b0;
            done  <= 1'b0;
            chr   <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                unique case (phase)
                    PH_IDLE: begin
                        if (!rx) begin
                            phase <= PH_START;
                            cnt   <= '0;
                        end
                    end
                    PH_START: begin
                        if (cnt == MID_CNT) begin
                            cnt   <= '0;
                            idx   <= '0;
                            shreg <= '0;
                            phase <= rx ? PH_IDLE : PH_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_DATA: begin
                        if (at_end) begin
                            cnt        <= '0;
                            shreg[idx] <= rx;
                            if (idx == LAST_BIT) begin
                                idx   <= '0;
                                phase <= PH_MPB;
                            end else begin
                                idx <= idx + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_MPB: begin
                        if (at_end) begin
                            cnt   <= '0;
                            mpb_q <= rx;
                            phase <= PH_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_STOP: begin
                        if (at_end) begin
                            cnt         <= '0;
                            phase       <= PH_IDLE;
                            done        <= 1'b1;
                            chr.data    <= shreg;
                            chr.mpb     <= mpb_q;
                            chr.stop_ok <= rx;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mpu_rx_regs.sv
// Module: receive data register, status flags, wake-up enable and
// interrupt pulse. A character is accepted when the wake-up enable is
// clear or its address bit is set. Accepted characters load the data
// register unless the previous one is unread (overrun).
// Assumes done is a single-cycle strobe.
module mpu_rx_regs
    import mpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  rx_char_t          chr,
    input  logic              wake_set,
    input  logic              rie,
    input  logic              rd_ack,
    input  logic              err_clr,
    output logic              wake_en,
    output logic [MAX_DW-1:0] data_q,
    output logic              mpb_flag,
    output logic              rdrf,
    output logic              orer,
    output logic              fer,
    output logic              irq
);
    logic accept;
    logic blocked;
    logic load;

    assign accept  = done && (!wake_en || chr.mpb);
    assign blocked = rdrf && !rd_ack;
    assign load    = accept && !blocked;

    // Wake-up enable: host sets it, an address character clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                wake_en <= 1'b0;
        else if (wake_set)         wake_en <= 1'b1;
        else if (done && chr.mpb)  wake_en <= 1'b0;
    end

    // Data register and address flag load on an accepted, unblocked character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q   <= '0;
            mpb_flag <= 1'b0;
        end else if (load) begin
            data_q   <= chr.data;
            mpb_flag <= chr.mpb;
        end
    end

    // Data-ready flag: set on load, cleared by the host read.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdrf <= 1'b0;
        else if (load)   rdrf <= 1'b1;
        else if (rd_ack) rdrf <= 1'b0;
    end

    // Overrun flag: accepted character arrives while data is unread.
    always_ff @(posedge clk) begin
        if (!rst_n)                  orer <= 1'b0;
        else if (accept && blocked)  orer <= 1'b1;
        else if (err_clr)            orer <= 1'b0;
    end

    // Framing flag: accepted character with a low stop bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                      fer <= 1'b0;
        else if (accept && !chr.stop_ok) fer <= 1'b1;
        else if (err_clr)                fer <= 1'b0;
    end

    // Interrupt pulse on each load while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= load && rie;
    end
endmodule

// File: rtl/mp_uart_rx.sv
// Module: top of the multiprocessor serial receiver. It chains the line
// synchronizer, the oversampled framer and the register stage.
// Assumes baud_tick runs at OSR times the bit rate; WIDE selects 9 data bits.
module mp_uart_rx
    import mpu_pkg::*;
#(
    parameter bit WIDE = 1'b0,
    parameter int OSR  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    input  logic       baud_tick,
    input  logic       wake_set,
    input  logic       rie,
    input  logic       rd_ack,
    input  logic       err_clr,
    output logic       wake_en,
    output logic [7:0] rdata_lo,
    output logic       rdata_hi,
    output logic       mpb_flag,
    output logic       rdrf,
    output logic       orer,
    output logic       fer,
    output logic       irq
);
    localparam int DATA_W = WIDE ? 9 : 8;

    logic              rx_s;
    logic              frm_done;
    rx_char_t          frm_chr;
    logic              frm_mpb;
    logic [MAX_DW-1:0] data_q;

    mpu_rx_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rx_s)
    );

    mpu_rx_framer #(.DATA_W(DATA_W), .OSR(OSR)) u_frm (
        .clk  (clk),
        .rst_n(rst_n),
        .rx   (rx_s),
        .tick (baud_tick),
        .done (frm_done),
        .chr  (frm_chr)
    );

    mpu_rx_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (frm_done),
        .chr     (frm_chr),
        .wake_set(wake_set),
        .rie     (rie),
        .rd_ack  (rd_ack),
        .err_clr (err_clr),
        .wake_en (wake_en),
        .data_q  (data_q),
        .mpb_flag(mpb_flag),
        .rdrf    (rdrf),
        .orer    (orer),
        .fer     (fer),
        .irq     (irq)
    );

    assign frm_mpb  = frm_chr.mpb;
    assign rdata_lo = data_q[7:0];
    assign rdata_hi = data_q[8];
endmodule

// File: rtl/mpu_rx_chk.sv
// Module: protocol checker for mp_uart_rx, attached through bind.
// Assumes it observes the framer strobe and the top-level ports.
module mpu_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frm_done,
    input logic       frm_mpb,
    input logic       wake_en,
    input logic       wake_set,
    input logic       rie,
    input logic       rd_ack,
    input logic       rdrf,
    input logic       orer,
    input logic       fer,
    input logic       irq,
    input logic [7:0] rdata_lo
);
    AST_IGNORED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && wake_en && !frm_mpb) |=>
            (!$rose(rdrf) && !$rose(orer) && !$rose(fer) && $stable(rdata_lo))); // R3

    AST_ID_CLEARS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && frm_mpb && !wake_set) |=> !wake_en); // R5

    AST_IRQ_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rdrf && $past(rie))); // R6

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R6

    AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && rdrf && !rd_ack && (!wake_en || frm_mpb)) |=>
            (orer && $stable(rdata_lo))); // R7
endmodule

bind mp_uart_rx mpu_rx_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .frm_done(frm_done),
    .frm_mpb (frm_mpb),
    .wake_en (wake_en),
    .wake_set(wake_set),
    .rie     (rie),
    .rd_ack  (rd_ack),
    .rdrf    (rdrf),
    .orer    (orer),
    .fer     (fer),
    .irq     (irq),
    .rdata_lo(rdata_lo)
);

// File: tb/sim_mp_uart_rx.sv
`timescale 1ns/1ps
module sim_mp_uart_rx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxd0 = 1'b1, rxd1 = 1'b1;
    logic wake_set = 1'b0, rie = 1'b0, rd_ack = 1'b0, err_clr = 1'b0;
    logic wake_en0, wake_en1, rdata_hi0, rdata_hi1, mpb0, mpb1;
    logic rdrf0, rdrf1, orer0, orer1, fer0, fer1, irq0, irq1;
    logic [7:0] rdata_lo0, rdata_lo1;
    int total = 0, bad = 0, irq_cnt = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    mp_uart_rx #(.WIDE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .rxd(rxd0), .baud_tick(1'b1),
        .wake_set(wake_set), .rie(rie), .rd_ack(rd_ack), .err_clr(err_clr),
        .wake_en(wake_en0), .rdata_lo(rdata_lo0), .rdata_hi(rdata_hi0),
        .mpb_flag(mpb0), .rdrf(rdrf0), .orer(orer0), .fer(fer0), .irq(irq0));

    mp_uart_rx #(.WIDE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .rxd(rxd1), .baud_tick(1'b1),
        .wake_set(1'b0), .rie(1'b0), .rd_ack(1'b0), .err_clr(1'b0),
        .wake_en(wake_en1), .rdata_lo(rdata_lo1), .rdata_hi(rdata_hi1),
        .mpb_flag(mpb1), .rdrf(rdrf1), .orer(orer1), .fer(fer1), .irq(irq1));

    always @(negedge clk) if (irq0) irq_cnt++;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bit_time(input bit v, input bit wide);
        if (wide) rxd1 = v; else rxd0 = v;
        repeat (16) @(negedge clk);
    endtask

    task automatic send(input logic [8:0] d, input bit mpb, input bit stop, input bit wide);
        bit_time(1'b0, wide);
        for (int i = 0; i < (wide ? 9 : 8); i++) bit_time(d[i], wide);
        bit_time(mpb, wide);
        bit_time(stop, wide);
        bit_time(1'b1, wide);
    endtask

    task automatic pulse_host(input bit ack, input bit clr, input bit wk);
        @(negedge clk);
        rd_ack = ack; err_clr = clr; wake_set = wk;
        @(negedge clk);
        rd_ack = 1'b0; err_clr = 1'b0; wake_set = 1'b0;
    endtask

    // {wake_pre, mpb, data, stop, e_rdrf, e_data, e_mpb, e_fer, e_wake}
    localparam int N = 6;
    localparam logic [22:0] VEC [N] = '{
        {1'b0, 1'b0, 8'hA5, 1'b1, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'h3C, 1'b1, 1'b1, 8'h3C, 1'b1, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'h55, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b0, 1'b1},
        {1'b1, 1'b0, 8'h77, 1'b0, 1'b0, 8'h3C, 1'b1, 1'b0, 1'b1},
        {1'b1, 1'b1, 8'h01, 1'b1, 1'b1, 8'h01, 1'b1, 1'b0, 1'b0},
        {1'b0, 1'b0, 8'hC3, 1'b0, 1'b1, 8'hC3, 1'b0, 1'b1, 1'b0}
    };

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 rdrf", rdrf0, 0);  chk("R9 orer", orer0, 0);
        chk("R9 fer", fer0, 0);    chk("R9 wake", wake_en0, 0);
        chk("R9 mpb", mpb0, 0);    chk("R9 data", rdata_lo0, 0);
        chk("R9 irq", irq0, 0);

        // Table: R2 accept, R3 ignore, R4 framing, R5 wake-up by address
        for (int k = 0; k < N; k++) begin
            pulse_host(1'b1, 1'b1, VEC[k][22]);
            send({1'b0, VEC[k][20:13]}, VEC[k][21], VEC[k][12], 1'b0);
            chk($sformatf("R2/R3/R5 rdrf v%0d", k), rdrf0, VEC[k][11]);
            chk($sformatf("R2/R3 data v%0d", k), rdata_lo0, VEC[k][10:3]);
            chk($sformatf("R2/R5 mpb v%0d", k), mpb0, VEC[k][2]);
            chk($sformatf("R4 fer v%0d", k), fer0, VEC[k][1]);
            chk($sformatf("R3/R5 wake v%0d", k), wake_en0, VEC[k][0]);
        end

        // R8 host clears and wake set
        pulse_host(1'b1, 1'b1, 1'b0);
        chk("R8 rdrf cleared", rdrf0, 0);
        chk("R8 fer cleared", fer0, 0);
        pulse_host(1'b0, 1'b0, 1'b1);
        chk("R8 wake set", wake_en0, 1);
        pulse_host(1'b0, 1'b0, 1'b0);
        send(9'h00B, 1'b1, 1'b1, 1'b0);   // address wakes it again

        // R7 overrun
        pulse_host(1'b1, 1'b1, 1'b0);
        send(9'h011, 1'b0, 1'b1, 1'b0);
        send(9'h022, 1'b0, 1'b1, 1'b0);
        chk("R7 orer", orer0, 1);
        chk("R7 data kept", rdata_lo0, 8'h11);
        chk("R7 rdrf", rdrf0, 1);

        // R6 interrupt behaviour
        pulse_host(1'b1, 1'b1, 1'b0);
        rie = 1'b1;
        irq_cnt = 0;
        send(9'h05A, 1'b0, 1'b1, 1'b0);
        chk("R6 irq on load", irq_cnt, 1);
        pulse_host(1'b1, 1'b0, 1'b1);
        send(9'h066, 1'b0, 1'b1, 1'b0);
        chk("R6 no irq when ignored", irq_cnt, 1);
        pulse_host(1'b0, 1'b0, 1'b0);
        rie = 1'b0;
        send(9'h002, 1'b1, 1'b1, 1'b0);
        chk("R6 no irq with rie 0", irq_cnt, 1);
        chk("R5 address loads", rdata_lo0, 8'h02);

        // R1 short low pulse is not a start; next frame still correct
        pulse_host(1'b1, 1'b1, 1'b0);
        rxd0 = 1'b0;
        repeat (4) @(negedge clk);
        rxd0 = 1'b1;
        repeat (200) @(negedge clk);
        chk("R1 glitch ignored", rdrf0, 0);
        send(9'h096, 1'b0, 1'b1, 1'b0);
        chk("R1 data after glitch", rdata_lo0, 8'h96);
        chk("R1 stop ok", fer0, 0);

        // R10 nine-bit mode
        send(9'h1A5, 1'b0, 1'b1, 1'b1);
        chk("R10 hi bit", rdata_hi1, 1);
        chk("R10 lo byte", rdata_lo1, 8'hA5);
        chk("R10 mpb wide", mpb1, 0);
        chk("R10 narrow hi zero", rdata_hi0, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(negedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule